// File: doc/BRIEF.md
# Four-Bit Parallel-Access Shift Register

This block is a small storage register of four stages that works in one of two modes on each rising clock edge. In load mode all four stages capture a four-bit parallel word at once. In shift mode the contents move one place toward the last stage. The first stage then takes a new bit that is worked out from two serial control inputs, one active-high and one active-low. Together they can hold, set, clear or flip the first stage. The last stage is the serial output, and its complement is also brought out. All four stages can be read in parallel at any time.

The mode input and the way the serial inputs are driven let the same hardware serve several roles:
- a serial-in/serial-out delay line;
- a serial-to-parallel converter;
- a parallel-in/parallel-out holding register.

An active-low clear empties the register at once, without waiting for a clock edge.

Top module: `par_access_shreg`

## Requirements
- R1: When shift_en is 0 at a rising edge of clk, q_out[3:0] takes the value of par_in[3:0], bit for bit.
- R2: When shift_en is 1 at a rising edge of clk, q_out[1] takes the old q_out[0], q_out[2] takes the old q_out[1], and q_out[3] takes the old q_out[2].
- R3: In shift mode the new q_out[0] depends on the old q_out[0] and on the pair (ser_j, ser_k_n). With ser_j=0 and ser_k_n=1 it keeps its old value (hold). With 1,1 it becomes 1 (set). With 0,0 it becomes 0 (reset). With 1,0 it becomes the inverse of the old value (toggle).
- R4: When ser_j and ser_k_n are tied to the same bit d, each shift puts d into q_out[0], so the register acts as a plain serial-data shift register.
- R5: clr_n is active low and asynchronous. While it is 0, q_out is 0000 from the moment it falls, even between clock edges, and clock edges do not change q_out.
- R6: tail_n is always the complement of q_out[3].
- R7: After a load of word w and k further shifts (k = 0..3), the serial output q_out[3] equals w[3-k].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| shift_en | input | 1 | 1 = shift toward stage 3, 0 = parallel load |
| ser_j | input | 1 | Serial control input, active high |
| ser_k_n | input | 1 | Serial control input, active low |
| par_in | input | 4 | Parallel load word; bit i goes to stage i |
| q_out | output | 4 | Stage contents; bit 3 is the serial output |
| tail_n | output | 1 | Complement of the last stage |

## Verification
Two situations are hard to reach. The first is the toggle and hold behaviour of the first stage, which has to be seen with that stage at both 0 and 1. The bench gets there by loading every one of the sixteen words and then shifting under each of the four serial-input pairs. The second is a clear that falls between two clock edges. The bench drops clr_n a fraction of a period after an edge, checks the outputs before the next edge, and then runs clock edges with the clear still held.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic {MODE_LOAD = 1'b0, MODE_SHIFT = 1'b1} psr_mode_e;

  // next value of the head stage from the serial control pair
  function automatic logic head_next(input logic j, input logic k_n, input logic q);
    return (j & ~q) | (k_n & q);
  endfunction
endpackage

// File: rtl/psr_head.sv
module psr_head (
  input  logic ser_j,
  input  logic ser_k_n,
  input  logic q_head,
  output logic head_nxt
);
  import psr_pkg::*;
  always_comb head_nxt = head_next(ser_j, ser_k_n, q_head);
endmodule

// File: rtl/psr_next.sv
module psr_next #(
  parameter int WIDTH = 4
) (
  input  psr_pkg::psr_mode_e mode,
  input  logic [WIDTH-1:0]   par_in,
  input  logic [WIDTH-1:0]   q_cur,
  input  logic               head_nxt,
  output logic [WIDTH-1:0]   q_nxt
);
  import psr_pkg::*;
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign q_nxt[i] = (mode == MODE_LOAD) ? par_in[i] : head_nxt;
    end else begin : g_body
      assign q_nxt[i] = (mode == MODE_LOAD) ? par_in[i] : q_cur[i-1];
    end
  end
endmodule

// File: rtl/psr_bank.sv
module psr_bank #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/par_access_shreg.sv
module par_access_shreg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             shift_en,
  input  logic             ser_j,
  input  logic             ser_k_n,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q_out,
  output logic             tail_n
);
  import psr_pkg::*;
  localparam int LAST = WIDTH - 1;

  psr_mode_e        mode;
  logic             head_nxt;
  logic [WIDTH-1:0] q_nxt;
  logic [WIDTH-1:0] q_reg;
  // named events for the checker
  logic             load_evt;
  logic             shift_evt;

  assign mode      = shift_en ? MODE_SHIFT : MODE_LOAD;
  assign load_evt  = clr_n && (mode == MODE_LOAD);
  assign shift_evt = clr_n && (mode == MODE_SHIFT);

  psr_head u_head (
    .ser_j    (ser_j),
    .ser_k_n  (ser_k_n),
    .q_head   (q_reg[0]),
    .head_nxt (head_nxt)
  );

  psr_next #(.WIDTH(WIDTH)) u_next (
    .mode     (mode),
    .par_in   (par_in),
    .q_cur    (q_reg),
    .head_nxt (head_nxt),
    .q_nxt    (q_nxt)
  );

  psr_bank #(.WIDTH(WIDTH)) u_bank (
    .clk   (clk),
    .clr_n (clr_n),
    .d     (q_nxt),
    .q     (q_reg)
  );

  assign q_out  = q_reg;
  assign tail_n = ~q_reg[LAST];
endmodule

// File: rtl/par_access_shreg_chk.sv
module par_access_shreg_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr_n,
  input logic             ser_j,
  input logic             ser_k_n,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] q_out,
  input logic             tail_n,
  input logic             load_evt,
  input logic             shift_evt
);
  // R1
  load_word_chk: assert property (@(posedge clk) disable iff (!clr_n)
    load_evt |=> q_out == $past(par_in));
  // R2
  shift_body_chk: assert property (@(posedge clk) disable iff (!clr_n)
    shift_evt |=> q_out[WIDTH-1:1] == $past(q_out[WIDTH-2:0]));
  // R3
  head_jk_chk: assert property (@(posedge clk) disable iff (!clr_n)
    shift_evt |=> q_out[0] == psr_pkg::head_next($past(ser_j), $past(ser_k_n), $past(q_out[0])));
  // R6
  tail_inv_chk: assert property (@(posedge clk) disable iff (!clr_n)
    tail_n != q_out[WIDTH-1]);
  // R5
  always @(negedge clk) begin
    if (!clr_n) clear_hold_chk: assert (q_out == '0);
  end
endmodule

bind par_access_shreg par_access_shreg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .ser_j     (ser_j),
  .ser_k_n   (ser_k_n),
  .par_in    (par_in),
  .q_out     (q_out),
  .tail_n    (tail_n),
  .load_evt  (load_evt),
  .shift_evt (shift_evt)
);

// File: tb/par_access_shreg_test.sv
module par_access_shreg_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       shift_en = 1'b0;
  logic       ser_j = 1'b0;
  logic       ser_k_n = 1'b0;
  logic [3:0] par_in = 4'h0;
  logic [3:0] q_out;
  logic       tail_n;

  int vectors = 0;
  int miscompares = 0;
  logic [3:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  par_access_shreg uut (
    .clk(clk), .clr_n(clr_n), .shift_en(shift_en), .ser_j(ser_j),
    .ser_k_n(ser_k_n), .par_in(par_in), .q_out(q_out), .tail_n(tail_n)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // wait for an edge, then sample after outputs settle
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // head stage rule written as a case table
  function automatic logic head_model(input logic j, input logic kn, input logic q);
    case ({j, kn})
      2'b01:   return q;     // hold
      2'b11:   return 1'b1;  // set
      2'b00:   return 1'b0;  // reset
      default: return ~q;    // toggle
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // reset state, R5 and R6
    tick();
    tick();
    chk("R5 reset", q_out, 4'h0);
    chk("R6 reset", {3'b0, tail_n}, 4'h1);
    clr_n = 1'b1;

    // sweep all words and all serial pairs
    for (int w = 0; w < 16; w++) begin
      for (int p = 0; p < 4; p++) begin
        shift_en = 1'b0;
        par_in = 4'(w);
        tick();
        model = 4'(w);
        chk("R1 load", q_out, model);
        chk("R7 serial k=0", {3'b0, q_out[3]}, {3'b0, model[3]});
        shift_en = 1'b1;
        ser_j = p[1];
        ser_k_n = p[0];
        par_in = ~par_in;  // must be ignored while shifting
        for (int k = 1; k <= 4; k++) begin
          tick();
          model = {model[2:0], head_model(ser_j, ser_k_n, model[0])};
          chk("R2/R3 shift", q_out, model);
          chk("R6 tail", {3'b0, tail_n}, {3'b0, ~model[3]});
          if (k < 4) begin
            logic [3:0] wv;
            wv = 4'(w);
            chk("R7 serial out", {3'b0, q_out[3]}, {3'b0, wv[3-k]});
          end
        end
      end
    end

    // R4: J tied to K_n streams a data word in
    shift_en = 1'b1;
    for (int s = 0; s < 8; s++) begin
      logic [7:0] pat;
      pat = 8'b1011_0010;
      ser_j = pat[s];
      ser_k_n = pat[s];
      tick();
      if (s >= 3) chk("R4 serial data", q_out, {pat[s-3], pat[s-2], pat[s-1], pat[s]});
    end

    // R5: clear falls between edges, then clock edges while held
    shift_en = 1'b0;
    par_in = 4'hF;
    tick();
    chk("R1 load F", q_out, 4'hF);
    #1;
    clr_n = 1'b0;
    #1;
    chk("R5 mid-cycle clear", q_out, 4'h0);
    chk("R6 after clear", {3'b0, tail_n}, 4'h1);
    for (int c = 0; c < 3; c++) begin
      tick();
      chk("R5 clear held", q_out, 4'h0);
    end
    @(negedge clk);
    clr_n = 1'b1;
    par_in = 4'h9;
    tick();
    chk("R1 load after clear", q_out, 4'h9);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule